// File: doc/BRIEF.md
# Glitchless Output Enable Gate

This block places a free-running source clock onto one output pad and removes it again without producing a shortened high or low pulse. Three active-low enable pins may be tied to the output through a link mask. The output runs only while every linked pin is low, so any linked pin that is high turns the output off. The combined request is synchronised to the source clock. The gate then opens or closes only at the instant when the running waveform already sits at the level the pad will hold. As a result, an enable starts a whole new cycle at a leading edge, and a disable lets the cycle in flight finish.

While the output is off, the pad is either driven low, driven high, or released with its output enable deasserted, which expresses high impedance. The running clock can be passed through unchanged or inverted. A power-down setting forces the pad inactive, with its output enable low and its data low, whatever the pins do. The configuration inputs (idle mode, invert) are meant to be static, or changed only while reset is applied.

Top module: `glitchless_oe_gate`

## Requirements
- R1: Enable pin i takes part only when link_mask[i]=1. The output runs when every linked pin is low and stops when any linked pin is high. Unlinked pins have no effect, and with no pin linked the output runs.
- R2: When the request turns on between clock edges, two synchroniser stages follow. With default parameters the first active source cycle of the pad then begins at the third rising source edge after the change. For an inverted output it begins at the falling edge that follows that rising edge. For a high idle level, the pad leaves its idle level at the first following edge of the opposite polarity.
- R3: When the request turns off, the cycle in flight completes in full. No phase of the running waveform is cut short, and the pad then settles on its idle level.
- R4: idle_mode=2'b00 (or 2'b11): a stopped output drives pad_data=0 with pad_oe=1.
- R5: idle_mode=2'b01: a stopped output drives pad_data=1 with pad_oe=1.
- R6: idle_mode=2'b10: pad_oe=0 and pad_data=0 while stopped. pad_oe=1 while running, and it rises while the running waveform is low.
- R7: While running, pad_data equals src_clk when invert=0 and its complement when invert=1.
- R8: While out_pwr_down=1, pad_oe=0 and pad_data=0 at once and at all times, regardless of pins and idle mode. After release, the output resumes through the normal enable path.
- R9: After reset the output is stopped and shows its idle level, with pad_oe as given by R4 to R6.
- R10: Around enable and disable transitions, no pulse on a driven pad_data is shorter than half a source period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source clock to be gated; also clocks the control logic |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin_n | input | NUM_PINS | Active-low enable pins, asynchronous |
| link_mask | input | NUM_PINS | Bit i links pin i to this output |
| idle_mode | input | 2 | Stopped level: 00 low, 01 high, 10 high impedance, 11 low |
| invert | input | 1 | 1 drives the complement of the source clock |
| out_pwr_down | input | 1 | 1 forces the pad inactive |
| pad_data | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Pad driver enable; 0 means high impedance |

## Verification
The gate has two internal registers, one updated on each source edge. A wrong value in the register not chosen by the configuration is invisible, but a wrong value in the chosen one shows on the pad within half a source period. It appears as an early or late start, a clipped phase, or a wrong idle level. Each enable and disable case is therefore sampled at both phases of the two cycles around the expected switch point, for every invert and idle-level combination. A pulse-width monitor reports any pad pulse shorter than half a period. A synchroniser fault shifts the switch point by whole cycles and is caught by the same phase-exact samples.

// File: rtl/oe_gate_pkg.sv
package oe_gate_pkg;

    typedef enum logic [1:0] {
        IDLE_LOW  = 2'b00,
        IDLE_HIGH = 2'b01,
        IDLE_HIZ  = 2'b10,
        IDLE_RSVD = 2'b11
    } idle_mode_e;

    typedef struct packed {
        idle_mode_e idle;
        logic       invert;
        logic       pwr_down;
    } gate_cfg_t;

    // Level held on the pad while stopped (the high-impedance mode parks data low)
    function automatic logic idle_level(input idle_mode_e m);
        return (m == IDLE_HIGH);
    endfunction

    // The running waveform equals the idle level right after the rising source
    // edge when invert XOR idle_level is 1; otherwise right after the falling edge.
    function automatic logic switch_on_rise(input gate_cfg_t c);
        return c.invert ^ idle_level(c.idle);
    endfunction

endpackage

// File: rtl/oeg_req_sync.sv
module oeg_req_sync #(
    parameter int NUM_PINS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_n,
    input  logic [NUM_PINS-1:0] mask,
    input  logic                pwr_down,
    output logic                run_req
);
    localparam int LAST = SYNC_STAGES - 1;

    logic want_on;
    logic [LAST:0] chain;

    // Any linked pin held high requests the stop; power-down also stops.
    assign want_on = !pwr_down && !(|(pin_n & mask));

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= want_on;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[LAST-1:0], want_on};
            end
        end
    endgenerate

    assign run_req = chain[LAST];
endmodule

// File: rtl/oeg_edge_gate.sv
module oeg_edge_gate (
    input  logic clk,
    input  logic rst,
    input  logic run_req,
    input  logic on_rise,
    output logic run
);
    logic run_pos;
    logic run_neg;

    always_ff @(posedge clk) begin
        if (rst) run_pos <= 1'b0;
        else     run_pos <= run_req;
    end

    always_ff @(negedge clk) begin
        if (rst) run_neg <= 1'b0;
        else     run_neg <= run_req;
    end

    assign run = on_rise ? run_pos : run_neg;
endmodule

// File: rtl/oeg_pad_mux.sv
module oeg_pad_mux
    import oe_gate_pkg::*;
(
    input  logic      clk,
    input  logic      run,
    input  gate_cfg_t cfg,
    output logic      pad_data,
    output logic      pad_oe
);
    logic wave;

    assign wave = clk ^ cfg.invert;

    always_comb begin
        if (cfg.pwr_down) begin
            pad_data = 1'b0;
            pad_oe   = 1'b0;
        end else if (run) begin
            pad_data = wave;
            pad_oe   = 1'b1;
        end else begin
            pad_data = idle_level(cfg.idle);
            pad_oe   = (cfg.idle != IDLE_HIZ);
        end
    end
endmodule

// File: rtl/glitchless_oe_gate.sv
module glitchless_oe_gate
    import oe_gate_pkg::*;
#(
    parameter int NUM_PINS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                src_clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] oe_pin_n,
    input  logic [NUM_PINS-1:0] link_mask,
    input  logic [1:0]          idle_mode,
    input  logic                invert,
    input  logic                out_pwr_down,
    output logic                pad_data,
    output logic                pad_oe
);
    gate_cfg_t cfg;
    logic      run_req;
    logic      run;

    assign cfg.idle     = idle_mode_e'(idle_mode);
    assign cfg.invert   = invert;
    assign cfg.pwr_down = out_pwr_down;

    oeg_req_sync #(
        .NUM_PINS   (NUM_PINS),
        .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
        .clk     (src_clk),
        .rst     (rst),
        .pin_n   (oe_pin_n),
        .mask    (link_mask),
        .pwr_down(out_pwr_down),
        .run_req (run_req)
    );

    oeg_edge_gate gate_i (
        .clk    (src_clk),
        .rst    (rst),
        .run_req(run_req),
        .on_rise(switch_on_rise(cfg)),
        .run    (run)
    );

    oeg_pad_mux mux_i (
        .clk     (src_clk),
        .run     (run),
        .cfg     (cfg),
        .pad_data(pad_data),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/oeg_checker.sv
module oeg_checker #(
    parameter int NUM_PINS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] pin_n,
    input logic [NUM_PINS-1:0] mask,
    input logic [1:0]          idle,
    input logic                pd,
    input logic                pad_data,
    input logic                pad_oe
);
    logic       want_on;
    logic [3:0] hist;
    logic       settled_off;
    logic       settled_on;

    assign want_on = !pd && !(|(pin_n & mask));

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[2:0], want_on};
    end

    assign settled_off = (hist == 4'h0);
    assign settled_on  = (hist == 4'hF);

    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        pd |-> (!pad_oe && !pad_data));

    assert_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
        (settled_off && !pd && (idle == 2'b00 || idle == 2'b11)) |-> (pad_oe && !pad_data));

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        (settled_off && !pd && idle == 2'b01) |-> (pad_oe && pad_data));

    assert_hiz_off_R6: assert property (@(posedge clk) disable iff (rst)
        (settled_off && !pd && idle == 2'b10) |-> !pad_oe);

    assert_run_oe_R6: assert property (@(posedge clk) disable iff (rst)
        (settled_on && !pd) |-> pad_oe);

    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == (idle != 2'b10 && !pd)));
endmodule

bind glitchless_oe_gate oeg_checker #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk     (src_clk),
    .rst     (rst),
    .pin_n   (oe_pin_n),
    .mask    (link_mask),
    .idle    (idle_mode),
    .pd      (out_pwr_down),
    .pad_data(pad_data),
    .pad_oe  (pad_oe)
);

// File: tb/glitchless_oe_gate_tb_top.sv
`timescale 1ns/1ps
module glitchless_oe_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] en_n = 3'b111;
    logic [2:0] mask = 3'b001;
    logic [1:0] idle = 2'b00;
    logic       inv = 1'b0;
    logic       pd = 1'b0;
    logic       pad_data;
    logic       pad_oe;

    int  checks = 0;
    int  fails = 0;
    int  glitches = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;
    time last_edge = 0;

    always #5 clk = ~clk;

    glitchless_oe_gate dut_i (
        .src_clk     (clk),
        .rst         (rst),
        .oe_pin_n    (en_n),
        .link_mask   (mask),
        .idle_mode   (idle),
        .invert      (inv),
        .out_pwr_down(pd),
        .pad_data    (pad_data),
        .pad_oe      (pad_oe)
    );

    // R10 pulse-width monitor
    always @(pad_data) begin
        if (mon_en && pad_oe && (($time - last_edge) < 5)) glitches++;
        last_edge = $time;
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic setup(input logic inv_i, input logic [1:0] idle_i);
        mon_en = 1'b0;
        @(posedge clk); #2;
        rst = 1'b1; pd = 1'b0; en_n = 3'b111; mask = 3'b001;
        inv = inv_i; idle = idle_i;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk); #2;
        chk(pad_oe, idle_i != 2'b10, "R9 reset pad_oe");
        chk(pad_data, idle_i == 2'b01, "R9 reset level");
    endtask

    // samples at P2+2, P2+7, P3+2, P3+7 after a pin change at P0+2
    task automatic window(input logic [3:0] exp, input string tag);
        repeat (2) @(posedge clk);
        #2 chk(pad_data, exp[3], {tag, " P2 high phase"});
        #5 chk(pad_data, exp[2], {tag, " P2 low phase"});
        @(posedge clk);
        #2 chk(pad_data, exp[1], {tag, " P3 high phase"});
        #5 chk(pad_data, exp[0], {tag, " P3 low phase"});
    endtask

    task automatic edge_case(input logic inv_i, input logic [1:0] idle_i,
                             input logic [3:0] en_exp, input logic [3:0] dis_exp,
                             input string name);
        setup(inv_i, idle_i);
        glitches = 0; last_edge = $time; mon_en = 1'b1;
        en_n = 3'b110;
        window(en_exp, {"R2 ", name, " enable"});
        repeat (3) begin
            @(posedge clk);
            #2 chk(pad_data, ~inv_i, {"R7 ", name, " running high phase"});
            #5 chk(pad_data, inv_i, {"R7 ", name, " running low phase"});
        end
        @(posedge clk); #2;
        en_n = 3'b111;
        window(dis_exp, {"R3 ", name, " disable"});
        repeat (3) @(posedge clk);
        #7;
        chk(pad_data, idle_i == 2'b01, {idle_i == 2'b01 ? "R5 " : "R4 ", name, " idle level"});
        chk(pad_oe, 1'b1, {idle_i == 2'b01 ? "R5 " : "R4 ", name, " idle drive"});
        mon_en = 1'b0;
        chk(glitches == 0, 1'b1, {"R10 ", name, " no short pulse"});
    endtask

    task automatic precedence_case();
        setup(1'b0, 2'b00);
        mask = 3'b101; en_n = 3'b010;
        repeat (4) @(posedge clk);
        @(posedge clk); #2 chk(pad_data, 1'b1, "R1 unlinked high pin ignored");
        en_n = 3'b110;
        repeat (4) @(posedge clk);
        @(posedge clk); #2 chk(pad_data, 1'b0, "R1 linked high pin disables");
        en_n = 3'b100;
        repeat (4) @(posedge clk);
        @(posedge clk); #2 chk(pad_data, 1'b0, "R1 disable wins over linked low pin");
        mask = 3'b000; en_n = 3'b111;
        repeat (4) @(posedge clk);
        @(posedge clk); #2 chk(pad_data, 1'b1, "R1 no linked pin runs");
        mask = 3'b111; en_n = 3'b000;
        repeat (4) @(posedge clk);
        @(posedge clk); #2 chk(pad_data, 1'b1, "R1 all linked low runs");
    endtask

    task automatic hiz_case();
        setup(1'b0, 2'b10);
        en_n = 3'b110;
        repeat (2) @(posedge clk);
        #2 chk(pad_oe, 1'b0, "R6 oe still off in high phase");
        #5 chk(pad_oe, 1'b1, "R6 oe on in low phase");
        chk(pad_data, 1'b0, "R6 oe rises while wave low");
        @(posedge clk); #2 chk(pad_data, 1'b1, "R6 running");
        en_n = 3'b111;
        repeat (4) @(posedge clk);
        #2 chk(pad_oe, 1'b0, "R6 oe off when stopped");
        chk(pad_data, 1'b0, "R6 data parked low");
    endtask

    task automatic pd_case();
        setup(1'b0, 2'b00);
        en_n = 3'b110;
        repeat (4) @(posedge clk);
        @(posedge clk); #2 chk(pad_data, 1'b1, "R8 running before power-down");
        pd = 1'b1;
        #1 chk(pad_oe, 1'b0, "R8 oe drops at once");
        chk(pad_data, 1'b0, "R8 data drops at once");
        repeat (3) begin
            @(posedge clk);
            #2 chk(pad_data | pad_oe, 1'b0, "R8 quiet high phase");
            en_n = ~en_n;
            #5 chk(pad_data | pad_oe, 1'b0, "R8 quiet low phase");
        end
        en_n = 3'b110;
        @(posedge clk); #2 pd = 1'b0;
        repeat (4) @(posedge clk);
        #2 chk(pad_data, 1'b1, "R8 resumes after release");
        chk(pad_oe, 1'b1, "R8 oe after release");
        setup(1'b0, 2'b01);
        pd = 1'b1;
        #1 chk(pad_data | pad_oe, 1'b0, "R8 overrides high idle level");
        pd = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        edge_case(1'b0, 2'b00, 4'b0010, 4'b1000, "plain low-idle");
        edge_case(1'b0, 2'b01, 4'b1110, 4'b1011, "plain high-idle");
        edge_case(1'b1, 2'b00, 4'b0001, 4'b0100, "inverted low-idle");
        edge_case(1'b1, 2'b01, 4'b1101, 4'b0111, "inverted high-idle");
        edge_case(1'b0, 2'b11, 4'b0010, 4'b1000, "plain code-11 idle");
        precedence_case();
        hiz_case();
        pd_case();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule